// File: doc/BRIEF.md
# Banked Interrupt Distributor Register Bank

This block stores the per-interrupt state that an interrupt distributor shows to software. That state covers enable, pending, trigger configuration and priority, for `NUM_IRQ` interrupt lines (128 by default) shared by `NUM_CPU` processors (8 by default). Interrupts 0 to 31 are banked: each processor has its own copy, and the `regCpu` index on the access picks which copy is used. Interrupts 32 and above are one copy that every processor sees. Software reaches the bank through a single-cycle 32-bit register port. A read returns data in the same cycle. A write takes effect at the next clock edge.

Enable and pending state use separate set and clear views. A set view sets each bit written as 1. A clear view clears each bit written as 1. Both views read back the current bits. Interrupts 0 to 15 are software interrupts, and they can never be disabled. Trigger configuration is stored as one bit per interrupt, but software sees it as two bits per interrupt. The bank also holds a distributor-enable control bit, a read-only type word and a read-only identification word.

The bank drives three outputs: a flat vector of pending bits per processor, a flat vector of enable bits per processor, and the distributor-enable bit. The routing and prioritisation logic that sits next to the bank reads these outputs.

Top module: `dist_regbank`

## Requirements
- R1: After reset, the control bit, every pending bit, every configuration bit and every priority byte are 0. Every enable bit is 0, except that interrupts 0 to 15 of every processor read as enabled.
- R2: A write to a set-enable word (byte offset 0x100 + 4·k) sets each enable bit written as 1. A write to a clear-enable word (0x180 + 4·k) clears each enable bit written as 1. Bits written as 0 are unchanged. Both offsets read the current enable bits of interrupts 32·k to 32·k+31.
- R3: After any clear-enable write to word 0, bits 15:0 of that processor's enable word 0 read 1. Software interrupts therefore stay enabled.
- R4: A write to a set-pending word (0x200 + 4·k) sets each pending bit written as 1. A write to a clear-pending word (0x280 + 4·k) clears each pending bit written as 1. Both offsets read the current pending bits.
- R5: Banked state is selected by `regCpu`. Banked state is word 0 of the enable and pending views, priority words 0 to 7 and configuration words 0 and 1. A write to another processor's copy leaves the copy of the accessing processor unchanged. All other words are one shared copy.
- R6: The control word at offset 0x000 keeps only bit 0. It reads back as `{31'b0, bit0}`, and bit 0 drives `distEnable` from the cycle after the write.
- R7: The type word at offset 0x004 reads `((NUM_CPU-1) << 5) | (NUM_IRQ/32 - 1)`, which is 0xE3 for the default parameters. Writes to it have no effect.
- R8: The identification word at offset 0x008 reads `ID_WORD`. Writes to it have no effect.
- R9: Some offsets read as zero and drop writes. These are the group words (0x080 to 0x08F), the set-active and clear-active words (0x300 to 0x30F and 0x380 to 0x38F), and every offset outside the mapped regions. An example of an unmapped offset is 0x110, which lies just past the set-enable words.
- R10: Configuration word j (0xC00 + 4·j) covers interrupts 16·j to 16·j+15. For each interrupt i in that range, bit 2·(i−16·j)+1 holds the stored bit of interrupt i, and bit 2·(i−16·j) always reads 0. A write stores only the odd bits.
- R11: Any write to configuration word 0 sets all 32 banked configuration bits of the accessing processor to 1, whatever the write data. Words 0 and 1 then read 0xAAAAAAAA.
- R12: Priority word p (0x400 + 4·p) reads back the full 32-bit value last written to it, one byte per interrupt.
- R13: Bit `c*NUM_IRQ + i` of `pendVec` and of `enVec` is the pending or enable state of interrupt i as processor c sees it. The bit reflects a write from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access present this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regCpu | input | $clog2(NUM_CPU) | Index of the requesting processor; selects banked state |
| regAddr | input | 12 | Byte offset of the access (bits 1:0 ignored) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the access cycle; zero when idle |
| distEnable | output | 1 | Stored distributor-enable bit |
| pendVec | output | NUM_CPU·NUM_IRQ | Pending bits as seen by each processor |
| enVec | output | NUM_CPU·NUM_IRQ | Enable bits as seen by each processor |

## Verification
If a bank select is decoded wrongly, the fault shows up at the ports as one processor's write appearing in another processor's copy. It also shows up as a shared word that differs between processors, and the first read-back through a different `regCpu` exposes it. The output vectors bring the same state out one cycle after the write edge, so a bad set, clear or forced bit is visible at `pendVec`/`enVec` at once, without a read. Configuration packing errors appear as nonzero even bits or shifted odd bits on the very next read of that word.

// File: rtl/dist_pkg.sv
package dist_pkg;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CTL,
    RD_TYPE,
    RD_ID,
    RD_EN,
    RD_PEND,
    RD_PRIO,
    RD_CFG
  } rdSel_e;

  // Strobes from the decoder to the storage datapath
  typedef struct packed {
    logic   wrCtl;
    logic   setEn;
    logic   clrEn;
    logic   setPend;
    logic   clrPend;
    logic   wrPrio;
    logic   wrCfg;
    rdSel_e rdSel;
    logic [7:0] word;   // word index inside the selected region
  } strobe_t;

  localparam int OFS_GROUP   = 'h080;
  localparam int OFS_SET_EN  = 'h100;
  localparam int OFS_CLR_EN  = 'h180;
  localparam int OFS_SET_PND = 'h200;
  localparam int OFS_CLR_PND = 'h280;
  localparam int OFS_SET_ACT = 'h300;
  localparam int OFS_CLR_ACT = 'h380;
  localparam int OFS_PRIO    = 'h400;
  localparam int OFS_CFG     = 'hC00;

endpackage

// File: rtl/dist_ctrl.sv
module dist_ctrl
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 128
) (
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [11:0] regAddr,
  output strobe_t     strb
);

  localparam int BM_BYTES = NUM_IRQ / 8;
  localparam int PR_BYTES = NUM_IRQ;
  localparam int CF_BYTES = NUM_IRQ / 4;

  function automatic logic inRange(input logic [11:0] a, input int base, input int len);
    return (int'(a) >= base) && (int'(a) < base + len);
  endfunction

  function automatic logic [7:0] wordOf(input logic [11:0] a, input int base);
    return 8'((int'(a) - base) >> 2);
  endfunction

  always_comb begin
    strb = '0;
    if (regValid) begin
      if (regAddr[11:2] == 10'd0) begin
        strb.rdSel = RD_CTL;
        strb.wrCtl = regWrite;
      end else if (regAddr[11:2] == 10'd1) begin
        strb.rdSel = RD_TYPE;
      end else if (regAddr[11:2] == 10'd2) begin
        strb.rdSel = RD_ID;
      end else if (inRange(regAddr, OFS_SET_EN, BM_BYTES)) begin
        strb.rdSel = RD_EN;
        strb.setEn = regWrite;
        strb.word  = wordOf(regAddr, OFS_SET_EN);
      end else if (inRange(regAddr, OFS_CLR_EN, BM_BYTES)) begin
        strb.rdSel = RD_EN;
        strb.clrEn = regWrite;
        strb.word  = wordOf(regAddr, OFS_CLR_EN);
      end else if (inRange(regAddr, OFS_SET_PND, BM_BYTES)) begin
        strb.rdSel   = RD_PEND;
        strb.setPend = regWrite;
        strb.word    = wordOf(regAddr, OFS_SET_PND);
      end else if (inRange(regAddr, OFS_CLR_PND, BM_BYTES)) begin
        strb.rdSel   = RD_PEND;
        strb.clrPend = regWrite;
        strb.word    = wordOf(regAddr, OFS_CLR_PND);
      end else if (inRange(regAddr, OFS_PRIO, PR_BYTES)) begin
        strb.rdSel  = RD_PRIO;
        strb.wrPrio = regWrite;
        strb.word   = wordOf(regAddr, OFS_PRIO);
      end else if (inRange(regAddr, OFS_CFG, CF_BYTES)) begin
        strb.rdSel = RD_CFG;
        strb.wrCfg = regWrite;
        strb.word  = wordOf(regAddr, OFS_CFG);
      end
      // group, active and unmapped offsets: read zero, write dropped
    end
  end

endmodule

// File: rtl/dist_datapath.sv
module dist_datapath
  import dist_pkg::*;
#(
  parameter int          NUM_IRQ = 128,
  parameter int          NUM_CPU = 8,
  parameter logic [31:0] ID_WORD = 32'h0100_0A5C
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [$clog2(NUM_CPU)-1:0]  regCpu,
  input  logic [31:0]                 regWdata,
  output logic [31:0]                 regRdata,
  output logic                        distEnable,
  output logic [NUM_CPU*NUM_IRQ-1:0]  pendVec,
  output logic [NUM_CPU*NUM_IRQ-1:0]  enVec
);

  localparam int SH_W  = NUM_IRQ / 32 - 1;            // shared bitmap words
  localparam int SH_IW = (SH_W > 1) ? $clog2(SH_W) : 1;
  localparam int PB_W  = 8;                           // banked priority words
  localparam int PS_W  = NUM_IRQ / 4 - PB_W;          // shared priority words
  localparam int PS_IW = (PS_W > 1) ? $clog2(PS_W) : 1;
  localparam logic [31:0] TYPE_WORD = 32'(((NUM_CPU - 1) << 5) | (NUM_IRQ / 32 - 1));

  logic [31:0] enBk [NUM_CPU];
  logic [31:0] pdBk [NUM_CPU];
  logic [31:0] cfBk [NUM_CPU];
  logic [31:0] enSh [SH_W];
  logic [31:0] pdSh [SH_W];
  logic [31:0] cfSh [SH_W];
  logic [31:0] prBk [NUM_CPU][PB_W];
  logic [31:0] prSh [PS_W];
  logic        ctlEn;

  logic             bmBank;
  logic [SH_IW-1:0] shIdx;
  logic             cfBank;
  logic             cfHalf;
  logic [SH_IW-1:0] cfShIdx;
  logic             prBank;
  logic [2:0]       prBkIdx;
  logic [PS_IW-1:0] prShIdx;
  logic [31:0]      cfRaw;

  function automatic logic [31:0] expand(input logic [15:0] v);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) r[2*i+1] = v[i];
    return r;
  endfunction

  function automatic logic [15:0] compress(input logic [31:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[2*i+1];
    return r;
  endfunction

  always_comb begin
    bmBank  = (strb.word == 8'd0);
    shIdx   = SH_IW'(strb.word - 8'd1);
    cfHalf  = strb.word[0];
    cfBank  = (strb.word[7:1] == 7'd0);
    cfShIdx = SH_IW'({1'b0, strb.word[7:1]} - 8'd1);
    prBank  = (strb.word < 8'(PB_W));
    prBkIdx = strb.word[2:0];
    prShIdx = PS_IW'(strb.word - 8'(PB_W));
    cfRaw   = cfBank ? cfBk[regCpu] : cfSh[cfShIdx];
  end

  always_comb begin
    case (strb.rdSel)
      RD_CTL:  regRdata = {31'b0, ctlEn};
      RD_TYPE: regRdata = TYPE_WORD;
      RD_ID:   regRdata = ID_WORD;
      RD_EN:   regRdata = bmBank ? enBk[regCpu] : enSh[shIdx];
      RD_PEND: regRdata = bmBank ? pdBk[regCpu] : pdSh[shIdx];
      RD_PRIO: regRdata = prBank ? prBk[regCpu][prBkIdx] : prSh[prShIdx];
      RD_CFG:  regRdata = expand(cfHalf ? cfRaw[31:16] : cfRaw[15:0]);
      default: regRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlEn <= 1'b0;
      for (int c = 0; c < NUM_CPU; c++) begin
        enBk[c] <= 32'h0000_FFFF;
        pdBk[c] <= '0;
        cfBk[c] <= '0;
        for (int p = 0; p < PB_W; p++) prBk[c][p] <= '0;
      end
      for (int s = 0; s < SH_W; s++) begin
        enSh[s] <= '0;
        pdSh[s] <= '0;
        cfSh[s] <= '0;
      end
      for (int s = 0; s < PS_W; s++) prSh[s] <= '0;
    end else begin
      if (strb.wrCtl) ctlEn <= regWdata[0];

      if (strb.setEn) begin
        if (bmBank) enBk[regCpu] <= enBk[regCpu] | regWdata;
        else        enSh[shIdx]  <= enSh[shIdx] | regWdata;
      end
      if (strb.clrEn) begin
        if (bmBank) enBk[regCpu] <= (enBk[regCpu] & ~regWdata) | 32'h0000_FFFF;
        else        enSh[shIdx]  <= enSh[shIdx] & ~regWdata;
      end

      if (strb.setPend) begin
        if (bmBank) pdBk[regCpu] <= pdBk[regCpu] | regWdata;
        else        pdSh[shIdx]  <= pdSh[shIdx] | regWdata;
      end
      if (strb.clrPend) begin
        if (bmBank) pdBk[regCpu] <= pdBk[regCpu] & ~regWdata;
        else        pdSh[shIdx]  <= pdSh[shIdx] & ~regWdata;
      end

      if (strb.wrPrio) begin
        if (prBank) prBk[regCpu][prBkIdx] <= regWdata;
        else        prSh[prShIdx]         <= regWdata;
      end

      if (strb.wrCfg) begin
        if (strb.word == 8'd0)  cfBk[regCpu]         <= '1;
        else if (cfBank)        cfBk[regCpu][31:16]  <= compress(regWdata);
        else if (cfHalf)        cfSh[cfShIdx][31:16] <= compress(regWdata);
        else                    cfSh[cfShIdx][15:0]  <= compress(regWdata);
      end
    end
  end

  assign distEnable = ctlEn;

  logic [NUM_IRQ-33:0] enShFlat;
  logic [NUM_IRQ-33:0] pdShFlat;

  for (genvar s = 0; s < SH_W; s++) begin : g_flat
    assign enShFlat[s*32 +: 32] = enSh[s];
    assign pdShFlat[s*32 +: 32] = pdSh[s];
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign enVec[c*NUM_IRQ +: NUM_IRQ]   = {enShFlat, enBk[c]};
    assign pendVec[c*NUM_IRQ +: NUM_IRQ] = {pdShFlat, pdBk[c]};

    // R3
    sgi_always_on_chk: assert property (@(posedge clk) disable iff (!rstN)
      enVec[c*NUM_IRQ +: 16] == 16'hFFFF);
  end

  // R6
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtl |=> distEnable == $past(regWdata[0]));

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setPend && !bmBank) |=> ((pdSh[$past(shIdx)] & $past(regWdata)) == $past(regWdata)));

  // R10
  cfg_even_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_CFG) |-> ((regRdata & 32'h5555_5555) == 32'h0));

  // R11
  cfg_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCfg && strb.word == 8'd0) |=> (cfBk[$past(regCpu)] == 32'hFFFF_FFFF));

  // R9
  raz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_ZERO) |-> (regRdata == 32'h0));

endmodule

// File: rtl/dist_regbank.sv
module dist_regbank
  import dist_pkg::*;
#(
  parameter int          NUM_IRQ = 128,
  parameter int          NUM_CPU = 8,
  parameter logic [31:0] ID_WORD = 32'h0100_0A5C
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regValid,
  input  logic                        regWrite,
  input  logic [$clog2(NUM_CPU)-1:0]  regCpu,
  input  logic [11:0]                 regAddr,
  input  logic [31:0]                 regWdata,
  output logic [31:0]                 regRdata,
  output logic                        distEnable,
  output logic [NUM_CPU*NUM_IRQ-1:0]  pendVec,
  output logic [NUM_CPU*NUM_IRQ-1:0]  enVec
);

  strobe_t strb;

  dist_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strb     (strb)
  );

  dist_datapath #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_CPU (NUM_CPU),
    .ID_WORD (ID_WORD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regCpu     (regCpu),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .distEnable (distEnable),
    .pendVec    (pendVec),
    .enVec      (enVec)
  );

  // R7
  type_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && regAddr[11:2] == 10'd1) |->
      (regRdata == 32'(((NUM_CPU - 1) << 5) | (NUM_IRQ / 32 - 1))));

endmodule

// File: tb/dist_regbank_tb.sv
`timescale 1ns/1ps
module dist_regbank_tb;

  localparam int NI = 128;
  localparam int NC = 8;
  localparam logic [31:0] IDW = 32'h0100_0A5C;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regValid = 1'b0;
  logic             regWrite = 1'b0;
  logic [2:0]       regCpu = '0;
  logic [11:0]      regAddr = '0;
  logic [31:0]      regWdata = '0;
  logic [31:0]      regRdata;
  logic             distEnable;
  logic [NC*NI-1:0] pendVec;
  logic [NC*NI-1:0] enVec;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] exp;
    logic [11:0] addr;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  dist_regbank #(.NUM_IRQ(NI), .NUM_CPU(NC), .ID_WORD(IDW)) u_dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regCpu(regCpu), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .distEnable(distEnable),
    .pendVec(pendVec), .enVec(enVec)
  );

  // Monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    if (regValid && !regWrite && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (regRdata !== it.exp) begin
        failures++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, regRdata, it.exp);
      end
    end
  end

  task automatic rd(input int cpu, input logic [11:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    regValid = 1'b1; regWrite = 1'b0; regCpu = 3'(cpu); regAddr = a;
    sbq.push_back('{e, a, tag});
    @(posedge clk); #1;
    regValid = 1'b0;
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regValid = 1'b1; regWrite = 1'b1; regCpu = 3'(cpu); regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic chkv(input logic [NI-1:0] act, input logic [NI-1:0] e, input string tag);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(0, 12'h000, 32'h0, "R1 ctl");
    rd(3, 12'h100, 32'h0000_FFFF, "R1 en word0");
    rd(3, 12'h104, 32'h0, "R1 en word1");
    rd(0, 12'h200, 32'h0, "R1 pend");
    rd(0, 12'hC00, 32'h0, "R1 cfg");
    rd(0, 12'h400, 32'h0, "R1 prio");
    chkv(pendVec[0 +: NI], '0, "R1 pendVec");

    // R7 / R8 read-only words
    wr(0, 12'h004, 32'h0);
    rd(0, 12'h004, 32'h0000_00E3, "R7 type");
    wr(0, 12'h008, 32'hFFFF_FFFF);
    rd(5, 12'h008, IDW, "R8 id");

    // R2 shared enable set/clear
    wr(2, 12'h104, 32'h0000_00F0);
    rd(5, 12'h184, 32'h0000_00F0, "R2 set-en read via clear view");
    wr(6, 12'h184, 32'h0000_0030);
    rd(1, 12'h104, 32'h0000_00C0, "R2 clear-en");
    // R13 enable vector
    chkv(enVec[3*NI +: NI], {64'h0, 32'h0000_00C0, 32'h0000_FFFF}, "R13 enVec cpu3");

    // R3 / R5 banked enable and software interrupts
    wr(1, 12'h100, 32'hFFFF_0000);
    rd(1, 12'h100, 32'hFFFF_FFFF, "R5 banked set cpu1");
    rd(0, 12'h100, 32'h0000_FFFF, "R5 cpu0 unaffected");
    wr(1, 12'h180, 32'hFFFF_FFFF);
    rd(1, 12'h100, 32'h0000_FFFF, "R3 software irqs forced on");

    // R4 pending set/clear
    wr(0, 12'h208, 32'h8000_0001);
    rd(3, 12'h288, 32'h8000_0001, "R4 set-pend");
    wr(0, 12'h288, 32'h0000_0001);
    rd(0, 12'h208, 32'h8000_0000, "R4 clear-pend");
    wr(4, 12'h200, 32'h0000_0005);
    rd(4, 12'h200, 32'h0000_0005, "R5 banked pend cpu4");
    rd(0, 12'h200, 32'h0, "R5 banked pend cpu0");
    chkv(pendVec[7*NI +: NI], NI'(32'h8000_0000) << 64, "R13 pendVec cpu7");
    chkv(pendVec[4*NI +: NI], (NI'(32'h8000_0000) << 64) | NI'(5), "R13 pendVec cpu4");

    // R6 control
    wr(0, 12'h000, 32'hFFFF_FFFF);
    rd(0, 12'h000, 32'h1, "R6 ctl set");
    checks++;
    if (distEnable !== 1'b1) begin failures++; $display("FAIL R6 distEnable actual=%b expected=1", distEnable); end
    wr(0, 12'h000, 32'h2);
    rd(0, 12'h000, 32'h0, "R6 ctl bit1 dropped");

    // R9 read-as-zero and unmapped
    wr(0, 12'h080, 32'hFFFF_FFFF);
    rd(0, 12'h080, 32'h0, "R9 group");
    rd(0, 12'h300, 32'h0, "R9 set-active");
    rd(0, 12'h380, 32'h0, "R9 clear-active");
    wr(0, 12'h500, 32'hFFFF_FFFF);
    rd(0, 12'h500, 32'h0, "R9 unmapped");
    wr(0, 12'h110, 32'hFFFF_FFFF);
    rd(0, 12'h100, 32'h0000_FFFF, "R9 write past enable dropped");

    // R10 configuration packing
    wr(0, 12'hC08, 32'hFFFF_FFFF);
    rd(0, 12'hC08, 32'hAAAA_AAAA, "R10 cfg odd bits only");
    wr(0, 12'hC08, 32'h0000_000A);
    rd(5, 12'hC08, 32'h0000_000A, "R10 cfg shared");
    rd(0, 12'hC0C, 32'h0, "R10 cfg neighbour");

    // R11 banked configuration force
    wr(2, 12'hC00, 32'h0);
    rd(2, 12'hC00, 32'hAAAA_AAAA, "R11 cfg word0 forced");
    rd(2, 12'hC04, 32'hAAAA_AAAA, "R11 cfg word1 forced");
    rd(3, 12'hC00, 32'h0, "R11 other cpu");
    wr(2, 12'hC04, 32'h0000_0008);
    rd(2, 12'hC04, 32'h0000_0008, "R11 word1 write");
    rd(2, 12'hC00, 32'hAAAA_AAAA, "R11 word0 kept");

    // R12 priority
    wr(1, 12'h400, 32'hDEAD_BEEF);
    rd(1, 12'h400, 32'hDEAD_BEEF, "R12 banked prio");
    rd(0, 12'h400, 32'h0, "R12 banked prio other cpu");
    wr(0, 12'h47C, 32'h1234_5678);
    rd(6, 12'h47C, 32'h1234_5678, "R12 shared prio");

    repeat (3) @(posedge clk);
    if (sbq.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule